// File: doc/BRIEF.md
# Event-Reporting Interrupt Controller

This block collects a parameterized number of level-sensitive interrupt lines (a whole multiple of 32) and a set of inter-processor requests, and presents each core with a single event register. A core reads that register to learn the next source it must service and what kind of source it is. The read is also the hand-off: the reported source is masked at the same clock edge, so it cannot be reported a second time. Software re-enables it later by writing the mask-clear bank.

All access goes through one 32-bit register port. Each access carries the index of the core making it. Per-line state lives in four banked words: software-trigger set, software-trigger clear, mask set and mask clear. Each line also has a routing register that selects the cores it may be delivered to. Inter-processor requests are raised by a send register that holds one bit per target core. Each core then acknowledges and unmasks its own request. Each core has an interrupt output that is high whenever its event register holds something to report.

Top module: `mmio_intc`

## Requirements
- R1: After reset every line mask and every core's inter-processor mask are set, software triggers, inter-processor requests and routing are zero, so all interrupt outputs are low and the event register reads 0 even with every input line high.
- R2: A read at 0x0004 returns the number of lines in bits 15:0, and a read at 0x2000 returns the index of the requesting core.
- R3: Mask words sit at 0x4100 + 4*(line/32) (set) and 0x4180 + 4*(line/32) (clear), with bit (line mod 32) covering the line. A 1 applies the action, a 0 leaves the bit alone, and a read at either address returns the current mask word, where 1 means masked.
- R4: Software-trigger words sit at 0x4000 + 4*(line/32) (set) and 0x4080 + 4*(line/32) (clear), with the same bit layout and write-one behaviour. They read back the trigger state. A set trigger makes its line active exactly as a high input does.
- R5: The routing register of a line sits at 0x3000 + 4*line and reads back. Its bit n allows delivery of that line to core n.
- R6: The event register at 0x2004 returns the type in bits 31:16 and the data in bits 15:0. Type 0 means nothing is pending and its data is 0. Type 1 means a line, with the line number as data. Type 4 means an inter-processor request, with data 1.
- R7: A line is eligible for a core when its input or its software trigger is high, its mask is clear, and its routing bit for that core is set. Among eligible lines the lowest-numbered one is reported.
- R8: A read of the event register that reports a line sets that line's mask bit at the same clock edge. The line is not reported again until it is unmasked, and it is reported again once unmasked if it is still active.
- R9: A write at 0x2008 raises an inter-processor request for every core whose bit is set. Writing bit 0 at 0x200C clears the requesting core's request, and writing bit 0 at 0x2028 clears its inter-processor mask. An unmasked request is reported before any line. Reporting it masks it again without clearing it.
- R10: The interrupt output of core n is high exactly when an event read by core n would return a non-zero type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_irq_i | input | NUM_LINES | Level-sensitive interrupt lines |
| reg_core_i | input | CW | Index of the core making the current access |
| reg_rd_i | input | 1 | Read strobe; reading the event register has side effects |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 16 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| core_irq_o | output | NUM_CORES | Per-core interrupt request |

## Verification
The event selection is driven first by a software trigger alone, then by a hardware level on a lower line. This separates the two trigger sources and shows that the lowest-numbered line wins. A line in the second bank word shows that selection crosses word boundaries. Repeated event reads with the lines still high show that each read masks what it reports, and the re-enable sequence shows that a line which is still active returns after it is unmasked. Routing to a single non-primary core, and a request pending on both an inter-processor source and a line, show which core is served and that the inter-processor request comes first.

// File: rtl/mmio_intc_pkg.sv
package mmio_intc_pkg;

  // Fixed register addresses (byte offsets)
  localparam logic [15:0] A_INFO       = 16'h0004;
  localparam logic [15:0] A_CORE_ID    = 16'h2000;
  localparam logic [15:0] A_EVENT      = 16'h2004;
  localparam logic [15:0] A_IPI_SEND   = 16'h2008;
  localparam logic [15:0] A_IPI_ACK    = 16'h200C;
  localparam logic [15:0] A_IPI_UNMASK = 16'h2028;

  // Routing window 0x3000..0x3FFF, bank window 0x4000..0x41FF
  localparam logic [3:0]  ROUTE_PAGE   = 4'h3;
  localparam logic [6:0]  BANK_PAGE    = 7'h20;

  // Bank operation, selected by address bits 8:7
  typedef enum logic [1:0] {
    BK_SW_SET   = 2'd0,
    BK_SW_CLR   = 2'd1,
    BK_MASK_SET = 2'd2,
    BK_MASK_CLR = 2'd3
  } bank_op_e;

  typedef enum logic [15:0] {
    EV_NONE = 16'd0,
    EV_LINE = 16'd1,
    EV_IPI  = 16'd4
  } ev_kind_e;

  localparam logic [15:0] IPI_KIND_OTHER = 16'd1;

  typedef struct packed {
    ev_kind_e    kind;
    logic [15:0] data;
  } evt_word_t;

endpackage

// File: rtl/intc_line_state.sv
module intc_line_state
  import mmio_intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int LW = $clog2(NUM_LINES),
  localparam int NUM_WORDS = NUM_LINES / 32,
  localparam int WW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bank_we,
  input  bank_op_e                            bank_op,
  input  logic [WW-1:0]                       bank_word,
  input  logic [31:0]                         bank_wdata,
  input  logic                                route_we,
  input  logic [LW-1:0]                       route_line,
  input  logic [NUM_CORES-1:0]                route_wdata,
  input  logic                                amask_vld,
  input  logic [LW-1:0]                       amask_line,
  output logic [NUM_LINES-1:0]                sw_q,
  output logic [NUM_LINES-1:0]                mask_q,
  output logic [NUM_LINES-1:0][NUM_CORES-1:0] route_q
);

  logic [NUM_LINES-1:0] sw_d;
  logic [NUM_LINES-1:0] mask_d;
  logic                 sw_en;
  logic                 mask_en;
  logic [WW+4:0]        base;

  assign base    = {bank_word, 5'd0};
  assign sw_en   = bank_we && (bank_op == BK_SW_SET || bank_op == BK_SW_CLR);
  assign mask_en = (bank_we && (bank_op == BK_MASK_SET || bank_op == BK_MASK_CLR))
                   || amask_vld;

  always_comb begin
    sw_d   = sw_q;
    mask_d = mask_q;
    if (bank_we) begin
      case (bank_op)
        BK_SW_SET:   sw_d[base +: 32]   = sw_q[base +: 32] | bank_wdata;
        BK_SW_CLR:   sw_d[base +: 32]   = sw_q[base +: 32] & ~bank_wdata;
        BK_MASK_SET: mask_d[base +: 32] = mask_q[base +: 32] | bank_wdata;
        BK_MASK_CLR: mask_d[base +: 32] = mask_q[base +: 32] & ~bank_wdata;
        default: ;
      endcase
    end
    // Hand-off mask from an event read takes effect at the same edge
    if (amask_vld) mask_d[amask_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sw_q <= '0;
    else if (sw_en)  sw_q <= sw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (mask_en)  mask_q <= mask_d;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_route
    logic route_en;
    assign route_en = route_we && (route_line == LW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         route_q[l] <= '0;
      else if (route_en)  route_q[l] <= route_wdata;
    end
  end

endmodule

// File: rtl/intc_ipi_state.sv
module intc_ipi_state #(
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send_we,
  input  logic [NUM_CORES-1:0] send_bits,
  input  logic                 ack_we,
  input  logic                 unmask_we,
  input  logic                 amask_we,
  input  logic [CW-1:0]        core_sel,
  output logic [NUM_CORES-1:0] pend_q,
  output logic [NUM_CORES-1:0] mask_q
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    logic pend_d, pend_en;
    logic mask_d, mask_en;

    assign hit = (core_sel == CW'(c));

    always_comb begin
      pend_en = 1'b0;
      pend_d  = pend_q[c];
      if (send_we && send_bits[c]) begin
        pend_en = 1'b1;
        pend_d  = 1'b1;
      end else if (ack_we && hit) begin
        pend_en = 1'b1;
        pend_d  = 1'b0;
      end
    end

    always_comb begin
      mask_en = 1'b0;
      mask_d  = mask_q[c];
      if (amask_we && hit) begin
        mask_en = 1'b1;
        mask_d  = 1'b1;
      end else if (unmask_we && hit) begin
        mask_en = 1'b1;
        mask_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[c] <= 1'b0;
      else if (pend_en)  pend_q[c] <= pend_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[c] <= 1'b1;
      else if (mask_en)  mask_q[c] <= mask_d;
    end
  end

endmodule

// File: rtl/intc_evt_pick.sv
module intc_evt_pick
  import mmio_intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] elig,
  input  logic                 ipi_live,
  output evt_word_t            evt
);

  logic          found;
  logic [LW-1:0] idx;

  // Scan downward so the lowest eligible index is the last one kept
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end

  always_comb begin
    if (ipi_live) begin
      evt.kind = EV_IPI;
      evt.data = IPI_KIND_OTHER;
    end else if (found) begin
      evt.kind = EV_LINE;
      evt.data = 16'(idx);
    end else begin
      evt.kind = EV_NONE;
      evt.data = 16'd0;
    end
  end

endmodule

// File: rtl/mmio_intc.sv
module mmio_intc
  import mmio_intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_irq_i,
  input  logic [CW-1:0]        reg_core_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [15:0]          reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [NUM_CORES-1:0] core_irq_o
);

  localparam int LW        = $clog2(NUM_LINES);
  localparam int NUM_WORDS = NUM_LINES / 32;
  localparam int WW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [5:0]  WORDS_LIM = 6'(NUM_WORDS);
  localparam logic [10:0] LINES_LIM = 11'(NUM_LINES);
  localparam logic [CW:0] CORES_LIM = (CW+1)'(NUM_CORES);

  // ---------------- reset release ----------------
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  // ---------------- address decode ----------------
  logic          in_bank, in_route, word_ok, line_ok, core_ok;
  logic [4:0]    word_raw;
  logic [9:0]    line_raw;
  logic [WW-1:0] bank_word;
  logic [LW-1:0] line_idx;
  bank_op_e      bank_op;

  assign in_bank   = (reg_addr_i[15:9] == BANK_PAGE);
  assign in_route  = (reg_addr_i[15:12] == ROUTE_PAGE);
  assign word_raw  = reg_addr_i[6:2];
  assign line_raw  = reg_addr_i[11:2];
  assign word_ok   = ({1'b0, word_raw} < WORDS_LIM);
  assign line_ok   = ({1'b0, line_raw} < LINES_LIM);
  assign core_ok   = ({1'b0, reg_core_i} < CORES_LIM);
  assign bank_word = word_raw[WW-1:0];
  assign line_idx  = line_raw[LW-1:0];
  assign bank_op   = bank_op_e'(reg_addr_i[8:7]);

  logic unused_addr;
  assign unused_addr = ^reg_addr_i[1:0];

  logic wr_bank, wr_route, wr_send, wr_ack, wr_unmask;
  assign wr_bank   = reg_wr_i && in_bank && word_ok;
  assign wr_route  = reg_wr_i && in_route && line_ok;
  assign wr_send   = reg_wr_i && (reg_addr_i == A_IPI_SEND);
  assign wr_ack    = reg_wr_i && (reg_addr_i == A_IPI_ACK) && reg_wdata_i[0] && core_ok;
  assign wr_unmask = reg_wr_i && (reg_addr_i == A_IPI_UNMASK) && reg_wdata_i[0] && core_ok;

  // ---------------- state ----------------
  logic [NUM_LINES-1:0]                sw_q, line_mask;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] route_q;
  logic [NUM_CORES-1:0]                ipi_pend, ipi_mask;
  logic                                amask_line_vld, amask_ipi;
  logic [LW-1:0]                       amask_line;

  intc_line_state #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_lines (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bank_we     (wr_bank),
    .bank_op     (bank_op),
    .bank_word   (bank_word),
    .bank_wdata  (reg_wdata_i),
    .route_we    (wr_route),
    .route_line  (line_idx),
    .route_wdata (reg_wdata_i[NUM_CORES-1:0]),
    .amask_vld   (amask_line_vld),
    .amask_line  (amask_line),
    .sw_q        (sw_q),
    .mask_q      (line_mask),
    .route_q     (route_q)
  );

  intc_ipi_state #(.NUM_CORES(NUM_CORES)) u_ipi (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .send_we   (wr_send),
    .send_bits (reg_wdata_i[NUM_CORES-1:0]),
    .ack_we    (wr_ack),
    .unmask_we (wr_unmask),
    .amask_we  (amask_ipi),
    .core_sel  (reg_core_i),
    .pend_q    (ipi_pend),
    .mask_q    (ipi_mask)
  );

  // ---------------- per-core event selection ----------------
  logic [NUM_LINES-1:0] line_live;
  logic [NUM_CORES-1:0] ipi_live;
  evt_word_t            evt_arr [NUM_CORES];

  assign line_live = (hw_irq_i | sw_q) & ~line_mask;
  assign ipi_live  = ipi_pend & ~ipi_mask;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_LINES-1:0] route_col;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_col
      assign route_col[l] = route_q[l][c];
    end

    intc_evt_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .elig     (line_live & route_col),
      .ipi_live (ipi_live[c]),
      .evt      (evt_arr[c])
    );

    assign core_irq_o[c] = (evt_arr[c].kind != EV_NONE);
  end

  // ---------------- event read hand-off ----------------
  evt_word_t cur_evt;
  logic      rd_evt;

  always_comb begin
    if (core_ok) cur_evt = evt_arr[reg_core_i];
    else         cur_evt = '{kind: EV_NONE, data: 16'd0};
  end

  assign rd_evt         = reg_rd_i && (reg_addr_i == A_EVENT) && core_ok;
  assign amask_line_vld = rd_evt && (cur_evt.kind == EV_LINE);
  assign amask_ipi      = rd_evt && (cur_evt.kind == EV_IPI);
  assign amask_line     = cur_evt.data[LW-1:0];

  // ---------------- read data ----------------
  logic [WW+4:0] rd_base;
  assign rd_base = {bank_word, 5'd0};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_INFO) begin
      reg_rdata_o = 32'(NUM_LINES);
    end else if (reg_addr_i == A_CORE_ID) begin
      reg_rdata_o = 32'(reg_core_i);
    end else if (reg_addr_i == A_EVENT) begin
      reg_rdata_o = cur_evt;
    end else if (in_route && line_ok) begin
      reg_rdata_o = 32'(route_q[line_idx]);
    end else if (in_bank && word_ok) begin
      if (bank_op == BK_SW_SET || bank_op == BK_SW_CLR)
        reg_rdata_o = sw_q[rd_base +: 32];
      else
        reg_rdata_o = line_mask[rd_base +: 32];
    end
  end

endmodule

// File: rtl/mmio_intc_chk.sv
module mmio_intc_chk #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LW = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_evt,
  input logic [CW-1:0]        reg_core_i,
  input logic [31:0]          reg_rdata_o,
  input logic [NUM_CORES-1:0] core_irq_o,
  input logic [NUM_LINES-1:0] line_mask,
  input logic [NUM_CORES-1:0] ipi_live
);

  logic          seen_q;
  logic          last_vld;
  logic [LW-1:0] last_idx;
  logic          unused_hi;

  assign unused_hi = ^reg_rdata_o[15:LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_idx <= '0;
    end else begin
      last_vld <= rd_evt && (reg_rdata_o[31:16] == 16'd1);
      last_idx <= reg_rdata_o[LW-1:0];
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (core_irq_o == '0));

  assert_event_type_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> ((reg_rdata_o[31:16] == 16'd0 && reg_rdata_o[15:0] == 16'd0) ||
                 reg_rdata_o[31:16] == 16'd1 ||
                (reg_rdata_o[31:16] == 16'd4 && reg_rdata_o[15:0] == 16'd1)));

  assert_handoff_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_vld |-> line_mask[last_idx]);

  assert_ipi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && ipi_live[reg_core_i]) |-> (reg_rdata_o == 32'h0004_0001));

  assert_irq_matches_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> (core_irq_o[reg_core_i] == (reg_rdata_o[31:16] != 16'd0)));

endmodule

bind mmio_intc mmio_intc_chk #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rd_evt      (rd_evt),
  .reg_core_i  (reg_core_i),
  .reg_rdata_o (reg_rdata_o),
  .core_irq_o  (core_irq_o),
  .line_mask   (line_mask),
  .ipi_live    (ipi_live)
);

// File: tb/sim_mmio_intc.sv
module sim_mmio_intc;

  localparam int NL = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] hw = '0;
  logic [1:0]    core = '0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mmio_intc #(.NUM_LINES(NL), .NUM_CORES(NC)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_irq_i    (hw),
    .reg_core_i  (core),
    .reg_rd_i    (rd),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .core_irq_o  (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] c, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    core = c; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] c, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    core = c; addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    hw = '1;
    do_reset();
    #1 chk("R1", "irq with all lines high", 32'(irq), 32'h0);
    bus_rd(0, 16'h2004, v); chk("R1", "event after reset", v, 32'h0);
    bus_rd(0, 16'h4100, v); chk("R1", "mask word0", v, 32'hFFFF_FFFF);
    bus_rd(0, 16'h4104, v); chk("R1", "mask word1", v, 32'hFFFF_FFFF);
    bus_rd(0, 16'h4000, v); chk("R1", "sw word0", v, 32'h0);
    bus_rd(0, 16'h30FC, v); chk("R1", "routing line 63", v, 32'h0);
    hw = '0;
  endtask

  task automatic t_info();
    logic [31:0] v;
    bus_rd(0, 16'h0004, v); chk("R2", "line count", v, 32'd64);
    for (int c = 0; c < NC; c++) begin
      bus_rd(2'(c), 16'h2000, v); chk("R2", "core index", v, 32'(c));
    end
  endtask

  task automatic t_mask_banks();
    logic [31:0] v;
    do_reset();
    bus_wr(0, 16'h4180, 32'h0000_00F0);
    bus_rd(0, 16'h4100, v); chk("R3", "after clear", v, 32'hFFFF_FF0F);
    bus_rd(0, 16'h4180, v); chk("R3", "read via clear addr", v, 32'hFFFF_FF0F);
    bus_rd(0, 16'h4184, v); chk("R3", "other word untouched", v, 32'hFFFF_FFFF);
    bus_wr(0, 16'h4100, 32'h0000_0030);
    bus_rd(0, 16'h4100, v); chk("R3", "after set", v, 32'hFFFF_FF3F);
    bus_wr(0, 16'h4100, 32'h0);
    bus_wr(0, 16'h4180, 32'h0);
    bus_rd(0, 16'h4100, v); chk("R3", "zero writes ignored", v, 32'hFFFF_FF3F);
  endtask

  task automatic t_lowest_and_handoff();
    logic [31:0] v;
    do_reset();
    bus_wr(0, 16'h300C, 32'h1);   // line 3 -> core 0
    bus_wr(0, 16'h3024, 32'h1);   // line 9 -> core 0
    bus_wr(0, 16'h30A0, 32'h1);   // line 40 -> core 0
    bus_rd(0, 16'h30A0, v); chk("R5", "routing readback", v, 32'h1);
    bus_wr(0, 16'h4180, 32'h0000_0208);
    bus_wr(0, 16'h4184, 32'h0000_0100);
    #1 chk("R10", "nothing active", 32'(irq), 32'h0);
    bus_wr(0, 16'h4000, 32'h0000_0200);
    #1 chk("R4", "sw trigger raises core0 only", 32'(irq), 32'h1);
    bus_rd(0, 16'h4000, v); chk("R4", "sw word readback", v, 32'h0000_0200);
    hw[3] = 1'b1;
    bus_rd(0, 16'h2004, v); chk("R7", "lowest line first", v, 32'h0001_0003);
    bus_rd(0, 16'h2004, v); chk("R8", "line 3 not repeated", v, 32'h0001_0009);
    bus_rd(0, 16'h4100, v); chk("R8", "both lines masked", v, 32'hFFFF_FFFF);
    bus_rd(0, 16'h2004, v); chk("R8", "nothing left", v, 32'h0);
    #1 chk("R10", "irq low after hand-off", 32'(irq), 32'h0);
    hw[40] = 1'b1;
    #1 chk("R10", "irq from word1 line", 32'(irq), 32'h1);
    bus_rd(0, 16'h2004, v); chk("R7", "word1 line number", v, 32'h0001_0028);
    bus_wr(0, 16'h4080, 32'h0000_0200);
    bus_rd(0, 16'h4000, v); chk("R4", "sw clear", v, 32'h0);
    bus_wr(0, 16'h4180, 32'h0000_0208);
    bus_rd(0, 16'h2004, v); chk("R8", "still-high line returns", v, 32'h0001_0003);
    bus_rd(0, 16'h2004, v); chk("R4", "cleared trigger gone", v, 32'h0);
    hw = '0;
  endtask

  task automatic t_routing();
    logic [31:0] v;
    do_reset();
    bus_wr(3, 16'h3008, 32'h2);   // line 2 -> core 1
    bus_rd(0, 16'h3008, v); chk("R5", "routing line 2", v, 32'h2);
    bus_wr(0, 16'h4180, 32'h4);
    hw[2] = 1'b1;
    #1 chk("R10", "only core1 interrupted", 32'(irq), 32'h2);
    bus_rd(0, 16'h2004, v); chk("R5", "core0 sees nothing", v, 32'h0);
    bus_rd(1, 16'h2004, v); chk("R5", "core1 sees line 2", v, 32'h0001_0002);
    hw = '0;
  endtask

  task automatic t_ipi();
    logic [31:0] v;
    do_reset();
    bus_wr(1, 16'h2008, 32'h5);
    #1 chk("R9", "requests masked at reset", 32'(irq), 32'h0);
    bus_wr(2, 16'h2028, 32'h1);
    #1 chk("R9", "core2 unmasked", 32'(irq), 32'h4);
    bus_wr(0, 16'h3000, 32'h4);
    bus_wr(0, 16'h4180, 32'h1);
    bus_wr(0, 16'h4000, 32'h1);
    bus_rd(2, 16'h2004, v); chk("R9", "request before line", v, 32'h0004_0001);
    bus_rd(2, 16'h2004, v); chk("R9", "then line 0", v, 32'h0001_0000);
    #1 chk("R10", "core2 quiet", 32'(irq), 32'h0);
    bus_wr(2, 16'h200C, 32'h1);
    bus_wr(2, 16'h2028, 32'h1);
    #1 chk("R9", "ack cleared request", 32'(irq), 32'h0);
    bus_rd(2, 16'h2004, v); chk("R9", "core2 empty", v, 32'h0);
    bus_wr(0, 16'h2028, 32'h1);
    #1 chk("R9", "core0 request kept", 32'(irq), 32'h1);
    bus_rd(0, 16'h2004, v); chk("R6", "request format", v, 32'h0004_0001);
    bus_wr(1, 16'h2028, 32'h1);
    #1 chk("R9", "core1 never targeted", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_info();
    t_mask_banks();
    t_lowest_and_handoff();
    t_routing();
    t_ipi();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule